// File: doc/BRIEF.md
# Selective Memory Wait-State Gate

This block sits beside an 8-bit microprocessor and drives its active-low wait line. It watches the memory-request, opcode-fetch, read and write strobes together with two region selects, one for a read-only block and one for a read/write block. When a memory cycle begins it decides whether that cycle needs extra time and, if so, stretches it by exactly one wait clock. Cycles that do not need the extra time run at full speed.

The decision comes from a 4-bit static configuration word. Each region has one enable for opcode-fetch cycles and one for ordinary data read/write cycles. A region can therefore run with no waits, with waits on fetches only, or with waits on every access. These three settings suit progressively slower memory parts: below roughly 275 ns, up to about 400 ns, and up to about 525 ns access time. Address decoding, I/O cycles, refresh and multi-clock waits are outside this block.

Inside the block, a combinational classifier picks the region and the enable bit that apply. A three-state controller holds the decision and shapes the wait pulse. Its states are DRAIN, ARMED and STRETCH. DRAIN goes to ARMED when memory-request is sampled high. ARMED goes to STRETCH when a memory cycle is detected and qualifies. ARMED goes to DRAIN when a memory cycle is detected but does not qualify. STRETCH always goes to DRAIN. ARMED stays in ARMED when no cycle is detected, and DRAIN stays in DRAIN while memory-request is low.

Top module: `ws_gate`

## Requirements
- R1: While `rst_n` is low, and after it rises, `wait_n` stays high until the first qualifying memory cycle is detected.
- R2: Configuration bit mapping: `wait_cfg[0]` enables waits on read-only-region fetches, `[1]` on read-only-region data reads/writes, `[2]` on read/write-region fetches, and `[3]` on read/write-region data reads/writes. A cycle is a fetch when `m1_n` is low at detection; otherwise it is a data cycle.
- R3: A qualifying cycle gets exactly one wait clock. `wait_n` is low for the single clock period that follows the detecting rising edge and is high again after the next edge.
- R4: A cycle is detected on a rising edge where the controller is armed, `mreq_n` is low, and at least one of `rd_n` and `wr_n` is low. While `mreq_n` is low with both strobes high, no wait is issued.
- R5: When both region selects are high, the read-only region's enables apply.
- R6: A memory cycle with neither region selected never produces a wait.
- R7: While `mreq_n` is high, no wait is issued, whatever the other strobes and selects are doing.
- R8: At most one wait is issued per assertion of `mreq_n`. The controller re-arms only after `mreq_n` has been sampled high, so a long cycle cannot produce a second wait.
- R9: Changing the selects or the configuration after the detecting edge neither cancels, extends nor repeats the wait of the current cycle.
- R10: With `wait_cfg` all zero, no access of any kind receives a wait.
- R11: If `mreq_n` is already low when reset is released, that cycle receives no wait. The next cycle, after `mreq_n` is released, is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all decisions are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | Active-low memory-request strobe |
| m1_n | input | 1 | Active-low opcode-fetch indicator |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| rom_sel | input | 1 | High when the cycle addresses the read-only region |
| ram_sel | input | 1 | High when the cycle addresses the read/write region |
| wait_cfg | input | 4 | Wait enables per region and cycle type (see R2) |
| wait_n | output | 1 | Active-low wait request to the CPU |

## Verification
The assertions assume a bus that holds `mreq_n` low for at least two rising edges per memory cycle. They also assume that the strobes, selects and configuration only change away from the rising edge. The bench meets both assumptions by driving every input on the falling edge and by keeping each access open for two edges before releasing it. The bench sweeps all 16 configurations against every pair of select values and against fetch, read and write cycles. It then runs the cases that stress the arming rule: a long cycle with mid-cycle changes, a request with no strobe, strobes without a request, and reset released in the middle of a cycle.

// File: rtl/ws_gate_pkg.sv
package ws_gate_pkg;

    // Number of memory regions with their own pair of enables.
    localparam int unsigned NUM_REGIONS = 2;
    // Enables per region: fetch, then data read/write.
    localparam int unsigned EN_PER_REGION = 2;
    localparam int unsigned CFG_W = NUM_REGIONS * EN_PER_REGION;
    localparam int unsigned REGION_IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    // Position of each enable inside a region's pair.
    localparam int unsigned EN_FETCH = 0;
    localparam int unsigned EN_DATA  = 1;

    typedef enum logic [1:0] {
        ST_DRAIN   = 2'd0,  // waiting for mreq_n to be released
        ST_ARMED   = 2'd1,  // ready to classify the next memory cycle
        ST_STRETCH = 2'd2   // wait line held low for one clock
    } gate_state_t;

    typedef struct packed {
        logic                    valid;   // some region is selected
        logic [REGION_IDX_W-1:0] region;  // winning region index
        logic                    fetch;   // opcode-fetch cycle
        logic                    needs;   // selected enable bit is set
    } cycle_class_t;

endpackage

// File: rtl/ws_gate_classify.sv
module ws_gate_classify
    import ws_gate_pkg::*;
(
    input  logic [NUM_REGIONS-1:0] region_sel,
    input  logic                   m1_n,
    input  logic [CFG_W-1:0]       cfg,
    output cycle_class_t           cls
);

    // Enable bit that applies to each region for the current cycle type.
    logic [NUM_REGIONS-1:0] region_en;

    genvar r;
    generate
        for (r = 0; r < NUM_REGIONS; r++) begin : g_region
            localparam int unsigned BASE = r * EN_PER_REGION;
            assign region_en[r] = (!m1_n) ? cfg[BASE + EN_FETCH]
                                          : cfg[BASE + EN_DATA];
        end
    endgenerate

    // Lowest-numbered selected region wins (read-only block is region 0).
    always_comb begin
        cls.valid  = 1'b0;
        cls.region = '0;
        cls.fetch  = !m1_n;
        cls.needs  = 1'b0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (region_sel[i]) begin
                cls.valid  = 1'b1;
                cls.region = REGION_IDX_W'(i);
                cls.needs  = region_en[i];
            end
        end
    end

endmodule

// File: rtl/ws_gate_fsm.sv
module ws_gate_fsm
    import ws_gate_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mreq_n,
    input  logic         strobe,     // rd or wr active
    input  cycle_class_t cls,
    output logic         wait_n
);

    gate_state_t state_q;
    gate_state_t state_d;

    logic detect;
    assign detect = !mreq_n && strobe;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DRAIN: begin
                if (mreq_n) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (detect) begin
                    if (cls.valid && cls.needs) state_d = ST_STRETCH;
                    else                        state_d = ST_DRAIN;
                end
            end
            ST_STRETCH: begin
                state_d = ST_DRAIN;
            end
            default: state_d = ST_DRAIN;
        endcase
    end

    // State register; reset lands in DRAIN so a cycle in flight is skipped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DRAIN;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_STRETCH: wait_n = 1'b0;
            ST_DRAIN,
            ST_ARMED:   wait_n = 1'b1;
            default:    wait_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/ws_gate.sv
module ws_gate
    import ws_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreq_n,
    input  logic             m1_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             rom_sel,
    input  logic             ram_sel,
    input  logic [CFG_W-1:0] wait_cfg,
    output logic             wait_n
);

    logic [NUM_REGIONS-1:0] region_sel;
    cycle_class_t           cls;
    logic                   strobe;

    assign region_sel = {ram_sel, rom_sel};
    assign strobe     = !rd_n || !wr_n;

    ws_gate_classify u_classify (
        .region_sel (region_sel),
        .m1_n       (m1_n),
        .cfg        (wait_cfg),
        .cls        (cls)
    );

    ws_gate_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .mreq_n (mreq_n),
        .strobe (strobe),
        .cls    (cls),
        .wait_n (wait_n)
    );

endmodule

// File: rtl/ws_gate_chk.sv
module ws_gate_chk
    import ws_gate_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mreq_n,
    input logic             rom_sel,
    input logic             ram_sel,
    input logic [CFG_W-1:0] wait_cfg,
    input logic             wait_n
);

    // Set once a wait has been seen in the current mreq_n assertion.
    logic waited_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      waited_q <= 1'b0;
        else if (mreq_n) waited_q <= 1'b0;
        else if (!wait_n) waited_q <= 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> wait_n);

    assert_single_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_n |=> wait_n);

    assert_no_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_sel && !ram_sel) |=> wait_n);

    assert_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |=> wait_n);

    assert_one_per_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_n |-> !waited_q);

    assert_zero_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cfg == '0) |=> wait_n);

endmodule

bind ws_gate ws_gate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mreq_n   (mreq_n),
    .rom_sel  (rom_sel),
    .ram_sel  (ram_sel),
    .wait_cfg (wait_cfg),
    .wait_n   (wait_n)
);

// File: tb/ws_gate_tb.sv
`timescale 1ns/1ps
module ws_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mreq_n = 1'b1;
    logic       m1_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rom_sel = 1'b0;
    logic       ram_sel = 1'b0;
    logic [3:0] wait_cfg = 4'h0;
    logic       wait_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    ws_gate u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mreq_n   (mreq_n),
        .m1_n     (m1_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .rom_sel  (rom_sel),
        .ram_sel  (ram_sel),
        .wait_cfg (wait_cfg),
        .wait_n   (wait_n)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: wait_n actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic bus_idle();
        mreq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    // kind: 0 fetch, 1 read, 2 write
    task automatic access(input logic [3:0] cfg, input logic rom, input logic ram,
                          input int kind);
        int   region;
        int   idx;
        logic q;
        string tag;
        @(negedge clk);
        wait_cfg = cfg; rom_sel = rom; ram_sel = ram;
        mreq_n = 1'b0;
        m1_n = (kind == 0) ? 1'b0 : 1'b1;
        rd_n = (kind == 2) ? 1'b1 : 1'b0;
        wr_n = (kind == 2) ? 1'b0 : 1'b1;
        region = rom ? 0 : (ram ? 1 : -1);
        idx = region * 2 + ((kind == 0) ? 0 : 1);
        q = (region >= 0) ? cfg[idx] : 1'b0;
        if (region < 0)            tag = "R6";
        else if (cfg == 4'h0)      tag = "R10";
        else if (rom && ram)       tag = "R5";
        else                       tag = "R2";
        @(negedge clk);
        check(wait_n, !q, tag);
        @(negedge clk);
        check(wait_n, 1'b1, "R3");
        bus_idle();
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: quiet in reset
        repeat (3) @(negedge clk);
        check(wait_n, 1'b1, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(wait_n, 1'b1, "R1 after reset");
        @(negedge clk);

        // Exhaustive sweep: R2 R3 R5 R6 R10
        for (int c = 0; c < 16; c++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 3; k++)
                    access(4'(c), s[0], s[1], k);

        // R7: strobes without mreq_n
        @(negedge clk);
        wait_cfg = 4'hF; rom_sel = 1'b1; ram_sel = 1'b0;
        rd_n = 1'b0; m1_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(wait_n, 1'b1, "R7");
        end
        bus_idle();
        @(negedge clk);

        // R4: mreq_n low without strobe, then strobe
        mreq_n = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check(wait_n, 1'b1, "R4 no strobe");
        end
        wr_n = 1'b0;
        @(negedge clk);
        check(wait_n, 1'b0, "R4 strobe");
        @(negedge clk);
        check(wait_n, 1'b1, "R4 end");
        bus_idle();
        @(negedge clk);

        // R8 / R9: long cycle with mid-cycle changes
        mreq_n = 1'b0; m1_n = 1'b0; rd_n = 1'b0;
        wait_cfg = 4'hF; rom_sel = 1'b1;
        @(negedge clk);
        wait_cfg = 4'h0; rom_sel = 1'b0;
        check(wait_n, 1'b0, "R9 latched");
        @(negedge clk);
        check(wait_n, 1'b1, "R9 not extended");
        wait_cfg = 4'hF; ram_sel = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(wait_n, 1'b1, "R8 long cycle");
        end
        bus_idle();
        @(negedge clk);

        // R11: reset released mid-cycle
        rst_n = 1'b0;
        mreq_n = 1'b0; rd_n = 1'b0; rom_sel = 1'b1; ram_sel = 1'b0; wait_cfg = 4'hF;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(wait_n, 1'b1, "R11 cycle in flight");
        end
        bus_idle();
        @(negedge clk);
        access(4'hF, 1'b1, 1'b0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule